// File: doc/BRIEF.md
# Overcurrent Shutdown Timer Bank

This block qualifies overcurrent events for a bank of output switches. Each switch has its own timer. The timer starts when the switch is commanded on and its "above overcurrent threshold" flag is asserted. If the flag holds for the full qualification delay, the switch is latched off. The block gives the latch-off mask to the output gating logic and the ORed overload status bit to the status report.

Two delays are available, and a single command bit chooses between them. A channel samples that bit at the moment its timer starts. After that, rewriting the command cannot shorten or lengthen a qualification already in progress. Both delays are counted in pulses of a tick enable, so the real time base comes from outside the block.

A latched channel stays off until a committed command frame carries the status-reset bit. The same commit applies the frame's new enable pattern. If the overcurrent is still present after the reset, the channel qualifies again and can trip again.

Top module: `oc_shutdown_bank`

## Requirements
- R1: After reset, every bit of `trip_mask` is 0 and `overload` is 0.
- R2: With `dly_short` = 0 when a channel's timer starts, the channel trips after its flag and enable have been held through `LONG_TICKS` tick pulses after the start cycle. With a tick on every cycle, `trip_mask` bit i is still 0 `LONG_TICKS` clocks after the flag is applied and is 1 one clock later.
- R3: With `dly_short` = 1 when the timer starts, the same holds with `SHORT_TICKS` in place of `LONG_TICKS`.
- R4: If the flag drops before expiry, the channel does not trip. Its timer clears, and a later assertion waits the full delay again.
- R5: Changing `dly_short` while a timer runs has no effect on that timer's delay.
- R6: `overload` is 1 exactly when at least one bit of `trip_mask` is 1.
- R7: A tripped channel stays tripped until a cycle with `commit` = 1 and `commit_srr` = 1. A commit with `commit_srr` = 0 leaves it tripped. The clear is visible in the clock after the commit.
- R8: The overcurrent flag of a channel whose `out_en` bit is 0 is ignored. Dropping `out_en` during qualification also clears that timer.
- R9: If the flag and enable persist through a status reset, the channel qualifies again from zero and trips again after the full delay.
- R10: The timer advances only on cycles with `tick` = 1. Without ticks, no channel trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base enable; one timer step per pulse |
| oc_flag | input | N_OUT | Per-channel "above overcurrent threshold" flag |
| out_en | input | N_OUT | Per-channel commanded-on state |
| dly_short | input | 1 | Delay select: 1 = short delay, 0 = long delay |
| commit | input | 1 | One-cycle strobe for a valid command frame |
| commit_srr | input | 1 | Status-reset bit of the committed frame |
| trip_mask | output | N_OUT | Per-channel latch-off mask for the output gating |
| overload | output | 1 | OR of all latch-off bits |

## Verification
On every cycle, the assertions check four things. A trip is held until a status-reset commit. The commit clears the trip in the next clock. A trip only ever follows a cycle with an enabled and flagged channel. The captured delay selection stays stable while a timer runs. They also check that the counter stays below the selected limit and that the overload bit agrees with the mask. Only the bench scenarios can show that the delays are exact to the clock in both selections on every channel. The same holds for the effects of dropping the flag or the enable mid-count, stalled ticks and re-tripping after a reset.

// File: rtl/oc_pkg.sv
package oc_pkg;
  // Delay, in tick pulses, chosen by the captured select bit.
  function automatic int unsigned delay_ticks(input logic sel_short,
                                              input int unsigned short_ticks,
                                              input int unsigned long_ticks);
    return sel_short ? short_ticks : long_ticks;
  endfunction

  // Counter width able to hold every value below the longer delay.
  function automatic int unsigned cnt_width(input int unsigned short_ticks,
                                            input int unsigned long_ticks);
    int unsigned mx;
    mx = (short_ticks > long_ticks) ? short_ticks : long_ticks;
    return (mx < 2) ? 1 : $clog2(mx);
  endfunction
endpackage

// File: rtl/oc_chan_timer.sv
module oc_chan_timer #(
  parameter int unsigned SHORT_TICKS = 25,
  parameter int unsigned LONG_TICKS  = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flag,
  input  logic en,
  input  logic sel_short,
  input  logic clr,
  output logic tripped
);
  localparam int unsigned CW = oc_pkg::cnt_width(SHORT_TICKS, LONG_TICKS);

  logic          run_q;
  logic          sel_q;
  logic [CW-1:0] cnt_q;
  logic          trip_q;
  logic          active;
  logic          expire;
  logic [CW-1:0] lim_m1;

  assign active  = en & flag & ~trip_q;
  assign lim_m1  = CW'(oc_pkg::delay_ticks(sel_q, SHORT_TICKS, LONG_TICKS) - 1);
  assign expire  = run_q & active & tick & (cnt_q == lim_m1);
  assign tripped = trip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sel_q  <= 1'b0;
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (clr) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (!active) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
      sel_q <= sel_short;
      cnt_q <= '0;
    end else if (expire) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      trip_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q && !clr |=> trip_q); // R7
  AST_SRR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !trip_q); // R7
  AST_TRIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past(en && flag && tick)); // R8
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && $past(run_q) |-> $stable(sel_q)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q <= lim_m1); // R2
endmodule

// File: rtl/oc_status_merge.sv
module oc_status_merge #(
  parameter int unsigned N_OUT = 12
) (
  input  logic [N_OUT-1:0] trips,
  output logic [N_OUT-1:0] mask,
  output logic             any_trip
);
  assign mask     = trips;
  assign any_trip = |trips;
endmodule

// File: rtl/oc_shutdown_bank.sv
module oc_shutdown_bank #(
  parameter int unsigned N_OUT       = 12,
  parameter int unsigned SHORT_TICKS = 25,
  parameter int unsigned LONG_TICKS  = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [N_OUT-1:0] oc_flag,
  input  logic [N_OUT-1:0] out_en,
  input  logic             dly_short,
  input  logic             commit,
  input  logic             commit_srr,
  output logic [N_OUT-1:0] trip_mask,
  output logic             overload
);
  logic             status_clr;
  logic [N_OUT-1:0] chan_trip;

  assign status_clr = commit & commit_srr;

  for (genvar g = 0; g < N_OUT; g++) begin : g_chan
    oc_chan_timer #(
      .SHORT_TICKS(SHORT_TICKS),
      .LONG_TICKS (LONG_TICKS)
    ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .flag     (oc_flag[g]),
      .en       (out_en[g]),
      .sel_short(dly_short),
      .clr      (status_clr),
      .tripped  (chan_trip[g])
    );
  end

  oc_status_merge #(.N_OUT(N_OUT)) u_merge (
    .trips   (chan_trip),
    .mask    (trip_mask),
    .any_trip(overload)
  );

  AST_OVL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    overload == (trip_mask != '0)); // R6
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    commit && commit_srr |=> !overload); // R7
endmodule

// File: tb/oc_shutdown_bank_tb.sv
module oc_shutdown_bank_tb;
  localparam int N   = 12;
  localparam int SH  = 3;
  localparam int LG  = 9;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [N-1:0] oc_flag = '0;
  logic [N-1:0] out_en = '0;
  logic dly_short = 1'b0;
  logic commit = 1'b0;
  logic commit_srr = 1'b0;
  logic [N-1:0] trip_mask;
  logic overload;
  int tests = 0;
  int fails = 0;

  oc_shutdown_bank #(.N_OUT(N), .SHORT_TICKS(SH), .LONG_TICKS(LG)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .oc_flag(oc_flag), .out_en(out_en),
    .dly_short(dly_short), .commit(commit), .commit_srr(commit_srr),
    .trip_mask(trip_mask), .overload(overload));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [N:0] act, input logic [N:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic srr_commit(input logic srr);
    commit = 1'b1; commit_srr = srr;
    cyc(1);
    commit = 1'b0; commit_srr = 1'b0;
  endtask

  function automatic logic [N:0] exp_state(input logic [N-1:0] m);
    return {(m != '0), m};
  endfunction

  initial begin
    cyc(2);
    check("R1", {overload, trip_mask}, '0);
    rst_n = 1'b1;
    cyc(1);
    check("R1", {overload, trip_mask}, '0);

    // R2/R3: every channel, both selections, exact trip cycle
    for (int ch = 0; ch < N; ch++) begin
      for (int s = 0; s < 2; s++) begin
        int d;
        d = (s == 1) ? SH : LG;
        dly_short = s[0];
        out_en = '1;
        oc_flag = '0; oc_flag[ch] = 1'b1;
        cyc(d);
        check(s ? "R3" : "R2", {overload, trip_mask}, '0);
        cyc(1);
        check(s ? "R3" : "R2", {overload, trip_mask}, exp_state(N'(1) << ch));
        oc_flag = '0;
        srr_commit(1'b0);
        check("R7", {overload, trip_mask}, exp_state(N'(1) << ch));
        srr_commit(1'b1);
        check("R7", {overload, trip_mask}, '0);
      end
    end

    // R4: drop before expiry, then full delay again
    dly_short = 1'b0;
    oc_flag = 12'h001;
    cyc(LG - 1);
    oc_flag = '0;
    cyc(1);
    check("R4", {overload, trip_mask}, '0);
    oc_flag = 12'h001;
    cyc(LG);
    check("R4", {overload, trip_mask}, '0);
    cyc(1);
    check("R4", {overload, trip_mask}, exp_state(12'h001));
    oc_flag = '0;
    srr_commit(1'b1);

    // R5: select changed mid-run
    dly_short = 1'b0;
    oc_flag = 12'h002;
    cyc(2);
    dly_short = 1'b1;
    cyc(LG - 2);
    check("R5", {overload, trip_mask}, '0);
    cyc(1);
    check("R5", {overload, trip_mask}, exp_state(12'h002));
    oc_flag = '0;
    srr_commit(1'b1);
    dly_short = 1'b1;
    oc_flag = 12'h004;
    cyc(1);
    dly_short = 1'b0;
    cyc(SH);
    check("R5", {overload, trip_mask}, exp_state(12'h004));
    oc_flag = '0;
    srr_commit(1'b1);

    // R6: two channels tripped, overload follows the mask
    dly_short = 1'b1;
    oc_flag = 12'h810;
    cyc(SH + 1);
    check("R6", {overload, trip_mask}, exp_state(12'h810));
    oc_flag = '0;
    srr_commit(1'b1);
    check("R6", {overload, trip_mask}, '0);

    // R8: disabled channel ignores its flag; disabling mid-count clears timer
    out_en = 12'hFDF;
    oc_flag = 12'h020;
    cyc(3 * LG);
    check("R8", {overload, trip_mask}, '0);
    dly_short = 1'b0;
    out_en = '1;
    cyc(LG - 1);
    out_en = 12'hFDF;
    cyc(1);
    out_en = '1;
    cyc(LG);
    check("R8", {overload, trip_mask}, '0);
    cyc(1);
    check("R8", {overload, trip_mask}, exp_state(12'h020));

    // R9: flag persists through the status reset: re-trips after full delay
    srr_commit(1'b1);
    check("R9", {overload, trip_mask}, '0);
    cyc(LG);
    check("R9", {overload, trip_mask}, '0);
    cyc(1);
    check("R9", {overload, trip_mask}, exp_state(12'h020));
    oc_flag = '0;
    srr_commit(1'b1);

    // R10: no ticks, no trip; ticks resume, counts continue
    tick = 1'b0;
    dly_short = 1'b1;
    oc_flag = 12'h100;
    cyc(5 * LG);
    check("R10", {overload, trip_mask}, '0);
    tick = 1'b1;
    cyc(SH - 1);
    check("R10", {overload, trip_mask}, '0);
    cyc(1);
    check("R10", {overload, trip_mask}, exp_state(12'h100));
    oc_flag = '0;
    srr_commit(1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule